// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block drives the SCL and SDA lines of an I2C master through the two sequences that close a byte. It can send the acknowledge bit after a received byte, or it can end the transfer with a Stop condition. Both lines are open-drain. The block outputs one drive-low enable per line and reads the real bus levels back through a two-flop synchronizer. Every timed step waits for the sensed level before it starts counting, so a slave that stretches the clock is honoured.

All timing comes from a reloadable down-counter. One period lasts `brg_reload + 1` system clocks. Software starts a sequence with a one-cycle request strobe, and the matching busy flag clears itself when the sequence finishes. At that point the interrupt flag is raised. A buffer write that arrives while a sequence runs is refused, and a collision flag records it.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset, neither line is driven low, and `ack_busy`, `stop_busy`, `irq_flag`, `stop_seen`, `wcol_flag` and `buf_q` are all zero.
- R2: An accepted acknowledge request does three things on the next edge: it pulls SCL low, drives SDA low when `ack_bit` is 0 (ACK) or leaves SDA released when `ack_bit` is 1 (NACK), and sets `ack_busy`. SCL is released one period (`brg_reload+1` clocks) later.
- R3: After the acknowledge releases SCL, the high-time count starts only once SCL is seen high through the synchronizer. SCL is pulled low again `P+3` clocks after the line actually rises, where P is one period. A slave holding SCL low therefore lengthens the sequence by exactly the time it holds the line.
- R4: When the acknowledge ends, SCL is pulled low and SDA is released. In the same cycle `ack_busy` clears and `irq_flag` sets, and SCL stays held low afterwards.
- R5: An accepted stop request sets `stop_busy` and drives SDA low while SCL is held low. Once SDA is seen low, one period is counted and SCL is released. This happens `P+3` clocks after the request edge.
- R6: During a stop, SDA is released `P+3` clocks after the SCL line actually rises.
- R7: `stop_seen` sets 3 clocks after the SDA line rises, provided SCL is high. One period later, `stop_busy` clears and `irq_flag` sets. Accepting any new request clears `stop_seen`.
- R8: A buffer write while both sequences are idle loads `buf_wdata` into `buf_q`. A buffer write during either sequence leaves `buf_q` unchanged and sets `wcol_flag`.
- R9: `irq_flag` and `wcol_flag` stay set until their clear strobe is pulsed. If a set and a clear happen in the same cycle, the flag sets.
- R10: A request that arrives while a sequence runs is ignored. If both requests arrive together while idle, the acknowledge is accepted and the stop is dropped.
- R11: A reload value of 0 gives a one-clock period.
- R12: Every wait for a sensed level ignores the synchronizer for the first two clocks of that wait. A level sampled before the block's own drive change is therefore never taken, even with a one-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brg_reload | input | BRG_W | Period reload value; a period is reload+1 clocks |
| ack_req | input | 1 | One-cycle request to start an acknowledge sequence |
| stop_req | input | 1 | One-cycle request to start a stop sequence |
| ack_bit | input | 1 | Acknowledge data: 0 sends ACK, 1 sends NACK |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | DATA_W | Buffer write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| ack_busy | output | 1 | Acknowledge sequence in progress |
| stop_busy | output | 1 | Stop sequence in progress |
| irq_flag | output | 1 | Sequence-complete interrupt flag |
| stop_seen | output | 1 | Stop condition observed on the bus |
| wcol_flag | output | 1 | Buffer write refused during a sequence |
| buf_q | output | DATA_W | Buffer contents |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |

## Verification
The bench builds the block with `BRG_W = 4` and `DATA_W = 8`. The 4-bit reload lets it reach both the one-clock period (reload 0) and the longest period (reload 15) in a short run. Between those extremes it uses reloads of 3 and 6, and it combines them with slave stretches of 0, 2, 3 and 5 clocks. The narrow counter also keeps every delay the scoreboard predicts small enough that all end-of-period and synchronizer edges are visited many times.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ACK_LOW,
        SQ_ACK_REL,
        SQ_ACK_HIGH,
        SQ_STP_SDA,
        SQ_STP_CNT1,
        SQ_STP_SCLW,
        SQ_STP_CNT2,
        SQ_STP_SDAW,
        SQ_STP_CNT3
    } seq_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    typedef struct packed {
        logic ack_done;
        logic stop_done;
        logic stop_mark;
    } seq_evt_t;

    function automatic logic is_ack_state(seq_state_e s);
        return (s == SQ_ACK_LOW) || (s == SQ_ACK_REL) || (s == SQ_ACK_HIGH);
    endfunction

    function automatic logic is_stop_state(seq_state_e s);
        return (s != SQ_IDLE) && !is_ack_state(s);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] line_sync
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [DEPTH-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[DEPTH-2:0], line_in[i]};
        end
        assign line_sync[i] = chain[DEPTH-1];
    end
endmodule

// File: rtl/i2c_brg_counter.sv
module i2c_brg_counter #(
    parameter int BRG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRG_W-1:0] reload,
    input  logic             load,
    input  logic             run,
    output logic             done
);
    logic [BRG_W-1:0] cnt_q;

    assign done = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= reload;
        else if (run)  cnt_q <= done ? reload : cnt_q - 1'b1;
    end

    // R11: each running cycle with a nonzero count steps down by one
    p_brg_step_r11: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ack_req,
    input  logic      stop_req,
    input  logic      ack_bit,
    input  logic      scl_s,
    input  logic      sda_s,
    input  logic      brg_done,
    output logic      brg_load,
    output logic      brg_run,
    output line_drv_t drv,
    output seq_evt_t  evt,
    output logic      ack_active,
    output logic      stop_active
);
    localparam logic [1:0] SETTLE = 2'(SYNC_DEPTH);

    seq_state_e state_q, state_d;
    line_drv_t  drv_q, drv_d;
    logic [1:0] age_q;
    logic       settled;

    assign settled = (age_q == SETTLE);

    always_comb begin
        state_d  = state_q;
        drv_d    = drv_q;
        brg_load = 1'b0;
        brg_run  = 1'b0;
        evt      = '0;
        unique case (state_q)
            SQ_IDLE: begin
                if (ack_req) begin
                    state_d       = SQ_ACK_LOW;
                    brg_load      = 1'b1;
                    drv_d.scl_low = 1'b1;
                    drv_d.sda_low = ~ack_bit;
                end else if (stop_req) begin
                    state_d       = SQ_STP_SDA;
                    drv_d.scl_low = 1'b1;
                    drv_d.sda_low = 1'b1;
                end
            end
            SQ_ACK_LOW: begin
                brg_run = 1'b1;
                if (brg_done) begin
                    state_d       = SQ_ACK_REL;
                    drv_d.scl_low = 1'b0;
                end
            end
            SQ_ACK_REL: begin
                if (settled && scl_s) begin
                    state_d  = SQ_ACK_HIGH;
                    brg_load = 1'b1;
                end
            end
            SQ_ACK_HIGH: begin
                brg_run = 1'b1;
                if (brg_done) begin
                    state_d       = SQ_IDLE;
                    drv_d.scl_low = 1'b1;
                    drv_d.sda_low = 1'b0;
                    evt.ack_done  = 1'b1;
                end
            end
            SQ_STP_SDA: begin
                if (settled && !sda_s) begin
                    state_d  = SQ_STP_CNT1;
                    brg_load = 1'b1;
                end
            end
            SQ_STP_CNT1: begin
                brg_run = 1'b1;
                if (brg_done) begin
                    state_d       = SQ_STP_SCLW;
                    drv_d.scl_low = 1'b0;
                end
            end
            SQ_STP_SCLW: begin
                if (settled && scl_s) begin
                    state_d  = SQ_STP_CNT2;
                    brg_load = 1'b1;
                end
            end
            SQ_STP_CNT2: begin
                brg_run = 1'b1;
                if (brg_done) begin
                    state_d       = SQ_STP_SDAW;
                    drv_d.sda_low = 1'b0;
                end
            end
            SQ_STP_SDAW: begin
                if (settled && sda_s && scl_s) begin
                    state_d       = SQ_STP_CNT3;
                    brg_load      = 1'b1;
                    evt.stop_mark = 1'b1;
                end
            end
            SQ_STP_CNT3: begin
                brg_run = 1'b1;
                if (brg_done) begin
                    state_d       = SQ_IDLE;
                    evt.stop_done = 1'b1;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            drv_q   <= '0;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            drv_q   <= drv_d;
            if (state_d != state_q) age_q <= '0;
            else if (!settled)      age_q <= age_q + 1'b1;
        end
    end

    assign drv         = drv_q;
    assign ack_active  = is_ack_state(state_q);
    assign stop_active = is_stop_state(state_q);

    // R3: SCL is only pulled low during the acknowledge after SCL was seen high
    p_ack_high_seen_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_ACK_HIGH && $past(state_q) == SQ_ACK_REL) |-> $past(scl_s));
    // R5: stop timing counts only once SDA is seen low
    p_stop_sda_seen_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_STP_CNT1 && $past(state_q) == SQ_STP_SDA) |-> !$past(sda_s));
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
    import i2c_seq_pkg::*;
#(
    parameter int BRG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BRG_W-1:0]  brg_reload,
    input  logic              ack_req,
    input  logic              stop_req,
    input  logic              ack_bit,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              ack_busy,
    output logic              stop_busy,
    output logic              irq_flag,
    output logic              stop_seen,
    output logic              wcol_flag,
    output logic [DATA_W-1:0] buf_q,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_s;
    logic             brg_load, brg_run, brg_done;
    line_drv_t        drv;
    seq_evt_t         evt;
    logic             busy, accept;

    i2c_line_sync #(.LINES(LINES), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst),
        .line_in({scl_in, sda_in}),
        .line_sync(line_s)
    );

    i2c_brg_counter #(.BRG_W(BRG_W)) u_brg (
        .clk(clk), .rst(rst), .reload(brg_reload),
        .load(brg_load), .run(brg_run), .done(brg_done)
    );

    i2c_seq_fsm u_fsm (
        .clk(clk), .rst(rst),
        .ack_req(ack_req), .stop_req(stop_req), .ack_bit(ack_bit),
        .scl_s(line_s[1]), .sda_s(line_s[0]),
        .brg_done(brg_done), .brg_load(brg_load), .brg_run(brg_run),
        .drv(drv), .evt(evt),
        .ack_active(ack_busy), .stop_active(stop_busy)
    );

    assign busy          = ack_busy | stop_busy;
    assign accept        = !busy && (ack_req || stop_req);
    assign scl_drive_low = drv.scl_low;
    assign sda_drive_low = drv.sda_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag  <= 1'b0;
            stop_seen <= 1'b0;
            wcol_flag <= 1'b0;
            buf_q     <= '0;
        end else begin
            if (evt.ack_done || evt.stop_done) irq_flag <= 1'b1;
            else if (irq_clr)                  irq_flag <= 1'b0;

            if (evt.stop_mark)  stop_seen <= 1'b1;
            else if (accept)    stop_seen <= 1'b0;

            if (buf_wr && busy) wcol_flag <= 1'b1;
            else if (wcol_clr)  wcol_flag <= 1'b0;

            if (buf_wr && !busy) buf_q <= buf_wdata;
        end
    end

    // R8: a write during a sequence is refused and flagged
    p_wcol_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && busy) |=> (wcol_flag && $stable(buf_q)));
    // R9: interrupt flag holds until cleared
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);
    // R10: never both sequences, and a stop request during an acknowledge is dropped
    p_one_seq_r10: assert property (@(posedge clk) disable iff (rst)
        !(ack_busy && stop_busy));
    p_ignore_req_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_busy && stop_req) |=> !stop_busy);
    // R4: acknowledge ends with SCL held, SDA released and the interrupt raised
    p_ack_end_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_busy) |-> (scl_drive_low && !sda_drive_low && irq_flag));
    // R7: stop is marked only with both lines released
    p_stop_lines_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_seen) |-> (!scl_drive_low && !sda_drive_low && stop_busy));
endmodule

// File: tb/i2c_ackstop_seq_tb.sv
module i2c_ackstop_seq_tb;
    localparam int BRG_W  = 4;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst = 1'b1;
    logic [BRG_W-1:0]  brg_reload = '0;
    logic              ack_req = 0, stop_req = 0, ack_bit = 0;
    logic              buf_wr = 0, irq_clr = 0, wcol_clr = 0;
    logic [DATA_W-1:0] buf_wdata = '0;
    logic              scl_in, sda_in, scl_hold = 0;
    logic              ack_busy, stop_busy, irq_flag, stop_seen, wcol_flag;
    logic [DATA_W-1:0] buf_q;
    logic              scl_drive_low, sda_drive_low;

    assign scl_in = ~(scl_drive_low | scl_hold);
    assign sda_in = ~sda_drive_low;

    i2c_ackstop_seq #(.BRG_W(BRG_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .brg_reload(brg_reload),
        .ack_req(ack_req), .stop_req(stop_req), .ack_bit(ack_bit),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .irq_clr(irq_clr), .wcol_clr(wcol_clr),
        .scl_in(scl_in), .sda_in(sda_in),
        .ack_busy(ack_busy), .stop_busy(stop_busy), .irq_flag(irq_flag),
        .stop_seen(stop_seen), .wcol_flag(wcol_flag), .buf_q(buf_q),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    typedef struct {
        logic [5:0] snap;
        int         delta;
        string      req;
    } item_t;

    item_t      q[$];
    logic [5:0] m = '0;
    int         n_chk = 0, n_fail = 0;
    int         stretch = 0, period = 1;
    bit         mon_on = 0;

    // bit 5 scl low, 4 sda low, 3 ack busy, 2 stop busy, 1 irq, 0 stop seen
    wire [5:0] watched = {scl_drive_low, sda_drive_low, ack_busy, stop_busy, irq_flag, stop_seen};

    // slave model: holds SCL low for `stretch` cycles after the master releases it
    initial begin
        int   hold_cnt;
        logic prev;
        hold_cnt = 0;
        prev = 0;
        forever begin
            @(negedge clk);
            if (prev && !scl_drive_low && stretch > 0) hold_cnt = stretch;
            else if (hold_cnt > 0) hold_cnt--;
            scl_hold = (hold_cnt > 0);
            prev = scl_drive_low;
        end
    end

    // monitor: pops expected items whenever the watched outputs change
    initial begin
        logic [5:0] last;
        int         cnt;
        item_t      it;
        last = '0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                cnt++;
                if (watched !== last) begin
                    n_chk++;
                    if (q.size() == 0) begin
                        n_fail++;
                        $display("FAIL unexpected change: actual %b expected %b", watched, last);
                    end else begin
                        it = q.pop_front();
                        if (watched !== it.snap || (it.delta >= 0 && it.delta != cnt)) begin
                            n_fail++;
                            $display("FAIL %s: actual %b after %0d cycles, expected %b after %0d",
                                     it.req, watched, cnt, it.snap, it.delta);
                        end
                    end
                    last = watched;
                    cnt = 0;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(int delta, string req);
        item_t it;
        it.snap = m;
        it.delta = delta;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic set_timing(int rl, int st);
        brg_reload = BRG_W'(rl);
        period = rl + 1;
        stretch = st;
    endtask

    task automatic pulse_req(bit a, bit s);
        @(negedge clk);
        ack_req = a;
        stop_req = s;
        @(negedge clk);
        ack_req = 0;
        stop_req = 0;
    endtask

    task automatic inject(bit wr, bit rq, bit wclr, logic [DATA_W-1:0] d);
        @(negedge clk);
        buf_wr = wr;
        buf_wdata = d;
        ack_req = rq;
        stop_req = rq;
        wcol_clr = wclr;
        @(negedge clk);
        buf_wr = 0;
        ack_req = 0;
        stop_req = 0;
        wcol_clr = 0;
    endtask

    task automatic wait_done();
        int k = 0;
        while ((q.size() != 0 || ack_busy || stop_busy) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 3000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: sequence did not finish, %0d items left, expected 0", q.size());
            q.delete();
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_ack(bit b, bit with_stop, bit wr, bit rq, bit wclr, logic [DATA_W-1:0] d);
        ack_bit = b;
        m[5] = 1; m[4] = ~b; m[3] = 1; m[0] = 0;
        push(-1, "R2");
        m[5] = 0;
        push(period, "R2");
        m[5] = 1; m[4] = 0; m[3] = 0; m[1] = 1;
        push(stretch + 3 + period, "R3,R4");
        pulse_req(1, with_stop);
        inject(wr, rq, wclr, d);
        wait_done();
    endtask

    task automatic run_stop(bit wr, bit rq, bit wclr, logic [DATA_W-1:0] d);
        m[5] = 1; m[4] = 1; m[2] = 1; m[0] = 0;
        push(-1, "R5");
        m[5] = 0;
        push(3 + period, "R5");
        m[4] = 0;
        push(stretch + 3 + period, "R6");
        m[0] = 1;
        push(3, "R7");
        m[2] = 0; m[1] = 1;
        push(period, "R7");
        pulse_req(0, 1);
        inject(wr, rq, wclr, d);
        wait_done();
    endtask

    task automatic clear_irq();
        if (m[1]) begin
            m[1] = 0;
            push(-1, "R9");
        end
        @(negedge clk);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run exceeded cycle limit, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {26'd0, watched}, 32'd0);
        chk("R1", {31'd0, wcol_flag}, 32'd0);
        chk("R1", {24'd0, buf_q}, 32'd0);
        mon_on = 1;

        // R8: idle write loads the buffer
        @(negedge clk);
        buf_wr = 1; buf_wdata = 8'hA5;
        @(negedge clk);
        buf_wr = 0;
        @(negedge clk);
        chk("R8", {24'd0, buf_q}, 32'hA5);

        // R11, R12: one-clock period, ACK started with SCL released
        set_timing(0, 0);
        run_ack(0, 0, 0, 0, 0, 8'h00);
        chk("R11", {31'd0, irq_flag}, 32'd1);
        chk("R12", {31'd0, scl_drive_low}, 32'd1);
        clear_irq();

        // NACK with a refused buffer write and ignored requests (R8, R10)
        set_timing(3, 0);
        run_ack(1, 0, 1, 1, 0, 8'h3C);
        chk("R8", {31'd0, wcol_flag}, 32'd1);
        chk("R8", {24'd0, buf_q}, 32'hA5);
        repeat (5) @(negedge clk);
        // R9: both flags still held before their clears
        chk("R9", {31'd0, wcol_flag}, 32'd1);
        chk("R9", {31'd0, irq_flag}, 32'd1);
        @(negedge clk); wcol_clr = 1;
        @(negedge clk); wcol_clr = 0;
        @(negedge clk);
        chk("R9", {31'd0, wcol_flag}, 32'd0);
        clear_irq();

        // stop with a stretching slave
        set_timing(3, 5);
        run_stop(0, 0, 0, 8'h00);
        chk("R7", {31'd0, stop_seen}, 32'd1);
        clear_irq();

        // R10: simultaneous requests, acknowledge wins
        set_timing(6, 2);
        run_ack(0, 1, 0, 0, 0, 8'h00);
        chk("R10", {31'd0, stop_seen}, 32'd0);
        chk("R10", {31'd0, stop_busy}, 32'd0);
        clear_irq();

        // R9: set and clear together keep the collision flag set; longest period
        set_timing(15, 0);
        run_stop(1, 0, 1, 8'h77);
        chk("R9", {31'd0, wcol_flag}, 32'd1);
        chk("R8", {24'd0, buf_q}, 32'hA5);
        clear_irq();
        @(negedge clk); wcol_clr = 1;
        @(negedge clk); wcol_clr = 0;

        // short period with stretch, stop from released bus
        set_timing(0, 3);
        run_stop(0, 1, 0, 8'h00);
        chk("R7", {31'd0, stop_seen}, 32'd1);
        chk("R6", {30'd0, scl_drive_low, sda_drive_low}, 32'd0);
        clear_irq();

        repeat (4) @(negedge clk);
        chk("R9", {26'd0, watched}, {26'd0, m});
        finish_run();
    end
endmodule